// File: doc/BRIEF.md
# Programmable RGB Dot-Clock Timing Generator

This block produces the line sync, frame sync and data-enable strobes for a parallel RGB panel. One counter walks the clocks of a line and a second walks the lines of a frame. The line total, the frame total, both sync pulse widths, the two wait counts that place the active window, and the active width and height all come from configuration inputs. A separate strobe marks each clock in which an active pixel should be taken from the pixel path. Clock generation and pixel fetch belong to other blocks.

Each of the three panel pins has its own active-level select. While sync output is switched off, all three pins sit at their idle level. A frame-base address written by the host into a shadow input moves into the current-address output only at the first clock of each frame. Software can therefore pan the display without tearing. When the run input rises, both counters restart at the first clock of the line sync pulse and the first line of the frame sync pulse.

Top module: `rgb_timing_gen`

## Requirements
- R1: While `run` is low, both counters are held at zero and every strobe is idle. In the first cycle that `run` is high, the position is pixel 0 of line 0.
- R2: A line lasts `h_total` clocks. Line sync is asserted in the clocks of a line whose index is below `h_pulse`.
- R3: A frame lasts `v_total` lines. Frame sync is asserted in the lines whose index is below `v_pulse`, and both values are counted in lines.
- R4: `pix_take` is high only when the clock index is in [`h_wait`, `h_wait`+`h_valid`), the line index is in [`v_wait`, `v_wait`+`v_active`), and sync output is on.
- R5: When `hs_high`, `vs_high` or `de_high` is 1, the matching pin is 1 while asserted and 0 when idle. When the select is 0, both levels are inverted.
- R6: When `de_present` is 0, `de_o` is held at 0 whatever the counters or the polarity select.
- R7: While `sync_on` is 0, `hsync_o`, `vsync_o` and `de_o` sit at their idle level and `pix_take` is 0. The counters keep running, so timing continues without a jump when `sync_on` returns to 1.
- R8: In the first clock of a frame (pixel 0, line 0, with `run` high), `next_base` is captured. The captured value appears on `cur_base` in the following cycle. At any other time, changes to `next_base` leave `cur_base` unchanged. `cur_base` resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Timing generator enable; a rise restarts the counters |
| sync_on | input | 1 | Gate for the panel strobes |
| h_total | input | 18 | Clocks per line |
| h_pulse | input | 14 | Line sync width in clocks |
| h_wait | input | 12 | Clocks from line start to the first active pixel |
| h_valid | input | 16 | Active pixels per line |
| v_total | input | 16 | Lines per frame |
| v_pulse | input | 18 | Frame sync width in lines |
| v_wait | input | 16 | Lines from frame start to the first active line |
| v_active | input | 16 | Active lines per frame |
| hs_high | input | 1 | Line sync active-high select |
| vs_high | input | 1 | Frame sync active-high select |
| de_high | input | 1 | Data-enable active-high select |
| de_present | input | 1 | Drives data-enable when 1, otherwise holds it at 0 |
| next_base | input | 32 | Shadow frame-base address |
| hsync_o | output | 1 | Line sync pin |
| vsync_o | output | 1 | Frame sync pin |
| de_o | output | 1 | Data-enable pin |
| pix_take | output | 1 | Active pixel strobe |
| cur_base | output | 32 | Frame-base address in use |

## Verification
If the line counter drifts, the line sync pulse and the window edges move within the same line, so a per-clock comparison catches the error within a few cycles. A fault in the line counter's carry into the frame counter first appears at the next line boundary, as frame sync or the window starting on the wrong line. A bad address swap appears one cycle after the frame's first clock, or when a mid-frame change to the shadow address reaches `cur_base`. The bench compares every pin in every clock against a position that it derives on its own from elapsed time.

// File: rtl/tg_pkg.sv
package tg_pkg;
  // true when c lies in the half-open range [s, s+l)
  function automatic logic in_span(input logic [31:0] c, input logic [31:0] s,
                                   input logic [31:0] l);
    logic [32:0] e;
    e = {1'b0, s} + {1'b0, l};
    return (c >= s) && ({1'b0, c} < e);
  endfunction

  // true during the leading w counts of a period
  function automatic logic lead_pulse(input logic [31:0] c, input logic [31:0] w);
    return c < w;
  endfunction

  // pin level for an asserted/idle state under a polarity select
  function automatic logic pin_level(input logic act, input logic high);
    return high ? act : ~act;
  endfunction
endpackage

// File: rtl/tg_span_counter.sv
module tg_span_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         adv,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W:0] ONE = (W+1)'(1);

  logic [W-1:0] cnt_q;

  assign wrap = adv && (({1'b0, cnt_q} + ONE) >= {1'b0, limit});
  assign cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (adv)    cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  // R2 and R3: a period ends by returning to zero
  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && adv && wrap) |=> (cnt_q == '0));
  // R3: without an advance the count holds
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !adv) |=> $stable(cnt_q));
  // R1: clear forces zero
  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
endmodule

// File: rtl/tg_pin_drive.sv
module tg_pin_drive (
  input  logic act,
  input  logic high,
  input  logic en,
  output logic pin
);
  import tg_pkg::*;
  assign pin = pin_level(en & act, high);
endmodule

// File: rtl/rgb_timing_gen.sv
module rgb_timing_gen #(
  parameter int HCW = 18,
  parameter int HPW = 14,
  parameter int HWW = 12,
  parameter int HAW = 16,
  parameter int VCW = 16,
  parameter int VPW = 18,
  parameter int VWW = 16,
  parameter int VAW = 16,
  parameter int AW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           sync_on,
  input  logic [HCW-1:0] h_total,
  input  logic [HPW-1:0] h_pulse,
  input  logic [HWW-1:0] h_wait,
  input  logic [HAW-1:0] h_valid,
  input  logic [VCW-1:0] v_total,
  input  logic [VPW-1:0] v_pulse,
  input  logic [VWW-1:0] v_wait,
  input  logic [VAW-1:0] v_active,
  input  logic           hs_high,
  input  logic           vs_high,
  input  logic           de_high,
  input  logic           de_present,
  input  logic [AW-1:0]  next_base,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic           pix_take,
  output logic [AW-1:0]  cur_base
);
  import tg_pkg::*;

  localparam int NPIN = 3;

  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;
  logic           line_end;
  logic           frame_end;
  logic           frame_start;
  logic           hs_act, vs_act, win_act;
  logic [NPIN-1:0] act_vec, high_vec, en_vec, pin_vec;
  logic [AW-1:0]  base_q;

  tg_span_counter #(.W(HCW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .clear(!run), .adv(run),
    .limit(h_total), .cnt(hcnt), .wrap(line_end)
  );

  tg_span_counter #(.W(VCW)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .clear(!run), .adv(run && line_end),
    .limit(v_total), .cnt(vcnt), .wrap(frame_end)
  );

  assign frame_start = run && (hcnt == '0) && (vcnt == '0);

  assign hs_act  = run && lead_pulse(32'(hcnt), 32'(h_pulse));
  assign vs_act  = run && lead_pulse(32'(vcnt), 32'(v_pulse));
  assign win_act = run && in_span(32'(hcnt), 32'(h_wait), 32'(h_valid))
                       && in_span(32'(vcnt), 32'(v_wait), 32'(v_active));

  assign act_vec  = {win_act, vs_act, hs_act};
  assign high_vec = {de_high, vs_high, hs_high};
  assign en_vec   = {sync_on && de_present, sync_on, sync_on};

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    tg_pin_drive u_pin (
      .act(act_vec[i]), .high(high_vec[i]), .en(en_vec[i]), .pin(pin_vec[i])
    );
  end

  assign hsync_o  = pin_vec[0];
  assign vsync_o  = pin_vec[1];
  assign de_o     = de_present ? pin_vec[2] : 1'b0;
  assign pix_take = sync_on && win_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           base_q <= '0;
    else if (frame_start) base_q <= next_base;
  end
  assign cur_base = base_q;

  // R1: a rise of run starts at pixel 0 of line 0
  assert_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (hcnt == '0 && vcnt == '0));
  // R8: the shadow address is captured at frame start
  assert_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (cur_base == $past(next_base)));
  // R8: otherwise the current address holds
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cur_base));
  // R7: strobes idle while sync output is off
  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_on |-> (hsync_o == !hs_high && vsync_o == !vs_high && !pix_take));
  // R6: absent enable pin stays low
  assert_noden_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !de_present |-> !de_o);
  // R4: a taken pixel always coincides with an asserted enable pin
  assert_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_take && de_present) |-> (de_o == de_high));
endmodule

// File: tb/rgb_timing_gen_bench.sv
module rgb_timing_gen_bench;
  localparam int HT = 10, HP = 2, HWT = 4, HV = 4;
  localparam int VT = 8,  VP = 2, VWT = 3, VA = 3;
  localparam int FR = HT * VT;

  logic clk = 0;
  logic rst_n = 0;
  logic run = 0, sync_on = 0;
  logic hs_high = 0, vs_high = 0, de_high = 0, de_present = 0;
  logic [31:0] next_base = 0;
  logic hsync_o, vsync_o, de_o, pix_take;
  logic [31:0] cur_base;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_cur = 0;

  always #5 clk = ~clk;

  rgb_timing_gen u_rgb_timing_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .sync_on(sync_on),
    .h_total(18'(HT)), .h_pulse(14'(HP)), .h_wait(12'(HWT)), .h_valid(16'(HV)),
    .v_total(16'(VT)), .v_pulse(18'(VP)), .v_wait(16'(VWT)), .v_active(16'(VA)),
    .hs_high(hs_high), .vs_high(vs_high), .de_high(de_high), .de_present(de_present),
    .next_base(next_base), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .pix_take(pix_take), .cur_base(cur_base)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // position-based expectation; t < 0 means run is low
  task automatic check_at(input int t);
    int h, v;
    bit hs, vs, win, so;
    h = (t < 0) ? 0 : t % HT;
    v = (t < 0) ? 0 : (t / HT) % VT;
    so = sync_on;
    hs = (t >= 0) && (h < HP);
    vs = (t >= 0) && (v < VP);
    win = (t >= 0) && (h >= HWT) && (h < HWT + HV) && (v >= VWT) && (v < VWT + VA);
    cmp((t == 0) ? "R1/R2/R5 hsync" : "R2/R5 hsync", 32'(hsync_o),
        32'(hs_high ? (so & hs) : !(so & hs)));
    cmp("R3/R5 vsync", 32'(vsync_o), 32'(vs_high ? (so & vs) : !(so & vs)));
    cmp("R4/R6 de", 32'(de_o),
        32'(de_present ? (de_high ? (so & win) : !(so & win)) : 1'b0));
    cmp("R4/R7 take", 32'(pix_take), 32'(so & win));
    cmp("R8 cur_base", cur_base, exp_cur);
    if (t >= 0 && (t % FR) == 0) exp_cur = next_base;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check_at(-1);            // reset state, R1
    rst_n = 1;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      run = 0;
      hs_high = c[0]; vs_high = c[1]; de_high = c[2]; de_present = c[3];
      sync_on = 1;
      for (int k = 0; k < 3; k++) begin   // R1: idle while run low
        #1 check_at(-1);
        @(negedge clk);
      end
      run = 1;
      for (int t = 0; t < FR + 25; t++) begin
        if (t == 13 || t == 57 || t == FR - 1) next_base = 32'h1000 * (c + 1) + 32'(t);
        sync_on = !(c[0] && t >= 20 && t < 45);   // R7 gaps
        #1 check_at(t);
        @(negedge clk);
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule